// File: doc/BRIEF.md
# Multiplexed Bidirectional Port Controller

This block is one 8-bit bidirectional port of a small microcontroller. It keeps an output register that the core writes over its internal data bus. For every pin it drives two enables, one for the pull-up transistor and one for the pull-down transistor. The analog pin structure and the external resistor sit outside the block. Two read strobes return data to the core. One returns the output register. The other returns the pin levels as they are sampled at the port.

A mode input chooses between two uses of the port. In general-purpose mode the pin behaves as open-drain: the pull-up is never enabled, a 0 in the register pulls the pin low, and a 1 leaves the pin floating. In bus mode both transistors follow an address/data byte, so each pin is driven actively either high or low.

A read-modify-write flag sends a pin read to the register path instead, so that the core sees the value it wrote last and not a pin level that an external load may have pulled. When the core asks for bus input (an instruction fetch or an external data read), the register is loaded with all ones. This releases every pull-down so that an external device can drive the pins. The all-ones value stays in the register after the bus cycle.

Top module: `mux_io_port`

## Requirements
- R1: After reset the output register holds all ones, `rd_data` is 0, and in general-purpose mode neither enable is set on any pin.
- R2: On a clock edge where `wr_en` is 1 and `bus_in_req` is 0, the register takes `wr_data`. On every other edge without `bus_in_req` it keeps its value.
- R3: With `bus_mode` 0, every bit of `hi_en` is 0 and `lo_en` equals the bitwise inverse of the register.
- R4: With `bus_mode` 1, `hi_en` equals `ad_out` and `lo_en` equals `~ad_out`. In no mode is a bit set in both `hi_en` and `lo_en`.
- R5: A clock edge with `rd_latch` 1 puts on `rd_data`, one cycle later, the register value from just before that edge.
- R6: A clock edge with `rd_pin` 1, `rd_latch` 0 and `rmw` 0 puts on `rd_data` the `pin_in` value sampled at that edge.
- R7: A clock edge with `rd_pin` 1 and `rmw` 1 returns the register value, as in R5, and not the pins.
- R8: An edge with neither strobe sets `rd_data` to 0. When both strobes are active, the register path wins.
- R9: An edge with `bus_in_req` 1 loads all ones into the register and overrides a write in the same cycle. The value stays after `bus_in_req` falls, and the earlier value does not come back.
- R10: In general-purpose mode, a pin whose register bit is 0 reads back as 0 through the pin path, whatever level is applied to it from outside.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the output register |
| wr_data | input | WIDTH | Data from the internal bus |
| rd_latch | input | 1 | Strobe that reads the register |
| rd_pin | input | 1 | Strobe that reads the pins |
| rmw | input | 1 | Read-modify-write flag; sends a pin read to the register path |
| bus_mode | input | 1 | 0 = general-purpose open-drain, 1 = push-pull address/data |
| ad_out | input | WIDTH | Address/data byte driven in bus mode |
| bus_in_req | input | 1 | Request for bus input; loads all ones into the register |
| pin_in | input | WIDTH | Pin levels as sampled |
| hi_en | output | WIDTH | Pull-up transistor enable, one bit per pin |
| lo_en | output | WIDTH | Pull-down transistor enable, one bit per pin |
| rd_data | output | WIDTH | Data returned to the internal bus |

## Verification
The driver enables are combinational. The bench checks them in the same cycle that it applies the inputs, before the next rising edge. The register and `rd_data` change at the rising edge that samples a strobe. The bench reads `rd_data` 1 ns after that edge and compares it with a model value. That model value is built from the register state before the edge and from the pin levels in effect at the edge. The bench resolves the pins itself from the enables and an external level, so a 0 in the register forces that pin to read 0.

// File: rtl/mux_io_port.sv
`timescale 1ns/1ps
module mux_io_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_latch,
  input  logic             rd_pin,
  input  logic             rmw,
  input  logic             bus_mode,
  input  logic [WIDTH-1:0] ad_out,
  input  logic             bus_in_req,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] hi_en,
  output logic [WIDTH-1:0] lo_en,
  output logic [WIDTH-1:0] rd_data
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] out_q;
  logic             take_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          out_q <= ALL_ONES;
    else if (bus_in_req) out_q <= ALL_ONES;
    else if (wr_en)      out_q <= wr_data;
  end

  assign hi_en = bus_mode ? ad_out  : '0;
  assign lo_en = bus_mode ? ~ad_out : ~out_q;

  assign take_reg = rd_latch | (rd_pin & rmw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_data <= '0;
    else if (take_reg) rd_data <= out_q;
    else if (rd_pin)   rd_data <= pin_in;
    else               rd_data <= '0;
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_in_req) |=> out_q == $past(wr_data));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !bus_in_req) |=> $stable(out_q));
  a_r4_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en & lo_en) == '0);
  a_r3_no_pullup_io: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> hi_en == '0);
  a_r5_latch_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |=> rd_data == $past(out_q));
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_latch && !rd_pin) |=> rd_data == '0);
  a_r9_ones_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_in_req |=> out_q == ALL_ONES);
endmodule

// File: tb/test_mux_io_port.sv
`timescale 1ns/1ps
module test_mux_io_port;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_latch = 0, rd_pin = 0, rmw = 0, bus_mode = 0, bus_in_req = 0;
  logic [W-1:0] wr_data = '0, ad_out = '0, ext = '1;
  logic [W-1:0] pin_in, hi_en, lo_en, rd_data;
  logic [W-1:0] m_reg;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < W; i++)
      pin_in[i] = lo_en[i] ? 1'b0 : (hi_en[i] ? 1'b1 : ext[i]);

  mux_io_port #(.WIDTH(W)) i_mux_io_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_latch(rd_latch), .rd_pin(rd_pin), .rmw(rmw), .bus_mode(bus_mode),
    .ad_out(ad_out), .bus_in_req(bus_in_req), .pin_in(pin_in),
    .hi_en(hi_en), .lo_en(lo_en), .rd_data(rd_data));

  function automatic logic [W-1:0] pins_of(input logic [W-1:0] lo, input logic [W-1:0] hi,
                                           input logic [W-1:0] e);
    return (~lo) & (hi | e);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [W-1:0] wd, input logic rl, input logic rp,
                     input logic rm, input logic bm, input logic [W-1:0] ad,
                     input logic bir, input logic [W-1:0] e, input string rtag);
    logic [W-1:0] ehi, elo, exp_rd;
    wr_en = we; wr_data = wd; rd_latch = rl; rd_pin = rp; rmw = rm;
    bus_mode = bm; ad_out = ad; bus_in_req = bir; ext = e;
    #1;
    ehi = bm ? ad : '0;
    elo = bm ? ~ad : ~m_reg;
    check(bm ? "R4 hi_en" : "R3 hi_en", hi_en, ehi);
    check(bm ? "R4 lo_en" : "R3 lo_en", lo_en, elo);
    check("R4 both enables", hi_en & lo_en, '0);
    if (rl || (rp && rm)) exp_rd = m_reg;
    else if (rp)          exp_rd = pins_of(elo, ehi, e);
    else                  exp_rd = '0;
    @(posedge clk);
    if (bir)     m_reg = '1;
    else if (we) m_reg = wd;
    #1;
    check(rtag, rd_data, exp_rd);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reg = '1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 rd_data", rd_data, '0);
    check("R1 lo_en", lo_en, '0);
    check("R1 hi_en", hi_en, '0);
    rst_n = 1;
    @(negedge clk);
    // R1: register reads all ones
    cyc(0, 8'h00, 1, 0, 0, 0, 8'h00, 0, 8'hFF, "R1 reg reset");
    // R2 write, then R5 read back
    cyc(1, 8'hA5, 0, 0, 0, 0, 8'h00, 0, 8'hFF, "R8 idle");
    cyc(0, 8'h00, 1, 0, 0, 0, 8'h00, 0, 8'hFF, "R5 latch read A5");
    // R5 read sees value before same-cycle write
    cyc(1, 8'h3C, 1, 0, 0, 0, 8'h00, 0, 8'hFF, "R5 pre-write value");
    cyc(0, 8'h00, 1, 0, 0, 0, 8'h00, 0, 8'hFF, "R2 written 3C");
    // R10: register 00, external all high, pin read gives 0
    cyc(1, 8'h00, 0, 0, 0, 0, 8'h00, 0, 8'hFF, "R8 idle");
    cyc(0, 8'h00, 0, 1, 0, 0, 8'h00, 0, 8'hFF, "R10 forced low");
    // R6 pin read with register ones, external pattern
    cyc(1, 8'hFF, 0, 0, 0, 0, 8'h00, 0, 8'h5A, "R8 idle");
    cyc(0, 8'h00, 0, 1, 0, 0, 8'h00, 0, 8'h5A, "R6 pin read 5A");
    // R7 rmw goes to register
    cyc(1, 8'h0F, 0, 0, 0, 0, 8'h00, 0, 8'hF0, "R8 idle");
    cyc(0, 8'h00, 0, 1, 1, 0, 8'h00, 0, 8'hF0, "R7 rmw read");
    // R8 both strobes: register wins
    cyc(0, 8'h00, 1, 1, 0, 0, 8'h00, 0, 8'hF0, "R8 both strobes");
    // R4 bus mode drive
    cyc(0, 8'h00, 0, 1, 0, 1, 8'hC3, 0, 8'h00, "R4 bus pin read");
    // R9 bus input load beats write, persists
    cyc(1, 8'h12, 0, 0, 0, 0, 8'h00, 1, 8'h77, "R9 load cycle");
    cyc(0, 8'h00, 0, 1, 0, 0, 8'h00, 0, 8'h77, "R9 external byte");
    cyc(0, 8'h00, 1, 0, 0, 0, 8'h00, 0, 8'h77, "R9 ones persist");
    begin
      int seed = 32'h1234;
      void'($urandom(seed));
      for (int n = 0; n < 3000; n++) begin
        logic [31:0] r;
        r = $urandom;
        cyc(r[0], W'($urandom), r[1], r[2], r[3], r[4], W'($urandom),
            (r[7:5] == 3'd0), W'($urandom), "R6 R7 R8 random read");
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule